// File: doc/BRIEF.md
# HDLC Transmit Message FIFO

This block sits on the transmit side of a bit-serial data link. A host pushes message octets into a 16-entry FIFO through a byte-wide register port. The port has two write addresses, selected here by `wr_last`. An ordinary octet goes through the first. The closing octet of a message goes through the second, which tags that FIFO entry as end of message. A serializer drains the FIFO and turns each message into an HDLC frame. The frame starts with an opening flag, carries the octets with zero-bit insertion, then the inverted CRC-16, and ends with a closing flag. The serializer emits one bit for each `bit_tick`.

When no message is waiting, the line carries back-to-back 0x7E flags. The closing flag of one frame may also serve as the opening flag of the next. If the FIFO runs dry before a tagged octet has been sent, the frame is aborted with eight ones and a sticky underrun status is raised. A read strobe copies the FIFO entry at the serializer's read pointer into the message register, so the host can see what goes out next.

Top module: `hdlc_tx_msg_fifo`

## Requirements
- R1: With an empty FIFO the stream is continuous flags 0x7E, sent LSB first as 0,1,1,1,1,1,1,0. Each `bit_tick` high in a cycle yields exactly one bit, on `tx_bit` with `tx_valid` high in the following cycle. `tx_valid` is low in every cycle after a cycle without a tick.
- R2: An accepted write with `wr_last`=0 stores a plain octet. An accepted write with `wr_last`=1 stores an octet tagged as the end of the current message.
- R3: The FIFO holds 16 octets, and `fifo_full` is high while it holds 16. A write while full is dropped and never reaches the line.
- R4: A message starts only after a complete flag. Its octets follow in write order, each LSB first.
- R5: Inside octets and FCS, a 0 is inserted after every run of five 1s. Flags and aborts are never stuffed.
- R6: After the tagged octet the block sends the ones-complement of a CRC-16 (x^16+x^12+x^5+1, register preset to all ones, processed LSB first). The low FCS octet goes first and each FCS octet is sent LSB first. A closing flag follows.
- R7: If an untagged octet ends while the FIFO is empty, the block sends eight 1s followed by flags and sets `underrun`. `underrun` stays high until the next accepted write.
- R8: The message register resets to 00h. An accepted write loads it with the written octet. A cycle with `rd_en` loads it instead with the octet at the read pointer. `rd_data` shows the new value from the next cycle.
- R9: A write and a serializer pop in the same cycle both take effect. No octet is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_last | input | 1 | Address select: 1 writes the final octet of a message |
| wr_data | input | 8 | Octet to write |
| rd_en | input | 1 | Latch the FIFO head into the message register |
| rd_data | output | 8 | Message register |
| bit_tick | input | 1 | Link bit slot enable |
| tx_bit | output | 1 | Serial line bit |
| tx_valid | output | 1 | Strobe marking a new `tx_bit` |
| fifo_full | output | 1 | FIFO holds 16 octets |
| underrun | output | 1 | Sticky abort status |

## Verification
The host write path and the serializer's pop share the FIFO occupancy, and both can land on the same clock edge. The bench queues one plain octet, then asserts the tagged closing octet in the very cycle whose tick ends the opening flag and pulls the first octet. The emitted bit stream must then carry both octets in order, with the correct FCS and a closing flag, against a stream the bench builds from its own stuffing and CRC model.

// File: rtl/hdlc_tx_msg_fifo.sv
module hdlc_tx_msg_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_last,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       bit_tick,
  output logic       tx_bit,
  output logic       tx_valid,
  output logic       fifo_full,
  output logic       underrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] FLAG = 8'h7E;

  typedef enum logic [2:0] {K_FLAG, K_DATA, K_FCSL, K_FCSH, K_ABORT} kind_t;

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [7:0]    msg_q, shreg;
  logic [3:0]    cnt;
  logic [2:0]    ones;
  logic          stuff_pend, last_q;
  logic [15:0]   crc, crc_next;
  kind_t         kind;

  logic empty, push, pop, consume, unit_end, stuffable;
  logic [8:0] head;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign fifo_full = (count == CW'(DEPTH));
  assign push      = wr_en & ~fifo_full;
  assign head      = mem[rptr];
  assign rd_data   = msg_q;
  assign stuffable = (kind == K_DATA) | (kind == K_FCSL) | (kind == K_FCSH);
  assign consume   = bit_tick & ~stuff_pend;
  assign unit_end  = consume & (cnt == 4'd1);
  assign pop       = unit_end & ~empty & ((kind == K_FLAG) | ((kind == K_DATA) & ~last_q));
  assign crc_next  = {1'b0, crc[15:1]} ^ ((crc[0] ^ shreg[0]) ? 16'h8408 : 16'h0000);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      msg_q    <= 8'h00;
      underrun <= 1'b0;
    end else begin
      if (push) wptr <= inc(wptr);
      if (pop)  rptr <= inc(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (rd_en)     msg_q <= head[7:0];
      else if (push) msg_q <= wr_data;
      if (unit_end && kind == K_DATA && !last_q && empty) underrun <= 1'b1;
      else if (push)                                      underrun <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind       <= K_FLAG;
      shreg      <= FLAG;
      cnt        <= 4'd8;
      ones       <= 3'd0;
      stuff_pend <= 1'b0;
      last_q     <= 1'b0;
      crc        <= 16'hFFFF;
      tx_bit     <= 1'b0;
      tx_valid   <= 1'b0;
    end else begin
      tx_valid <= bit_tick;
      if (bit_tick) tx_bit <= stuff_pend ? 1'b0 : shreg[0];
      if (bit_tick && stuff_pend) begin
        stuff_pend <= 1'b0;
        ones       <= 3'd0;
      end else if (consume) begin
        if (stuffable) begin
          ones       <= shreg[0] ? ones + 3'd1 : 3'd0;
          stuff_pend <= shreg[0] && (ones == 3'd4);
        end else begin
          ones <= 3'd0;
        end
        if (kind == K_DATA) crc <= crc_next;
        shreg <= {1'b0, shreg[7:1]};
        cnt   <= cnt - 4'd1;
        if (cnt == 4'd1) begin
          cnt <= 4'd8;
          case (kind)
            K_DATA: begin
              if (last_q) begin
                kind  <= K_FCSL;
                shreg <= ~crc_next[7:0];
              end else if (!empty) begin
                shreg  <= head[7:0];
                last_q <= head[8];
              end else begin
                kind  <= K_ABORT;
                shreg <= 8'hFF;
              end
            end
            K_FCSL: begin
              kind  <= K_FCSH;
              shreg <= ~crc[15:8];
            end
            K_FCSH, K_ABORT: begin
              kind  <= K_FLAG;
              shreg <= FLAG;
            end
            default: begin
              if (!empty) begin
                kind   <= K_DATA;
                shreg  <= head[7:0];
                last_q <= head[8];
                crc    <= 16'hFFFF;
              end else begin
                shreg <= FLAG;
              end
            end
          endcase
        end
      end
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !pop) |=> fifo_full);
  assert_zero_insert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_pend && bit_tick) |=> (tx_valid && !tx_bit));
  assert_run_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ones == 3'd5) |-> stuff_pend);
  assert_abort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (kind == K_ABORT));
  assert_strobe_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> tx_valid);
  assert_strobe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> !tx_valid);
endmodule

// File: tb/tb_hdlc_tx_msg_fifo.sv
module tb_hdlc_tx_msg_fifo;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_last = 0, rd_en = 0, bit_tick = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic tx_bit, tx_valid, fifo_full, underrun;

  hdlc_tx_msg_fifo #(.DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_last(wr_last), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .bit_tick(bit_tick), .tx_bit(tx_bit),
    .tx_valid(tx_valid), .fifo_full(fifo_full), .underrun(underrun));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int exp_q[$];
  int got_q[$];
  int ones_m;
  logic [15:0] crc_m;
  logic [7:0] mb [16];
  int mn;

  localparam logic [71:0] VEC [5] = '{
    {8'd1, 56'h0, 8'h00},
    {8'd2, 48'h0, 16'hFFFF},
    {8'd3, 40'h0, 24'hF83E7E},
    {8'd8, 64'hEFCDAB8967452301},
    {8'd2, 48'h0, 16'hF01F}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic m_flag();
    for (int i = 0; i < 8; i++) exp_q.push_back((8'h7E >> i) & 1);
    ones_m = 0;
  endtask

  task automatic m_bit(int b);
    exp_q.push_back(b);
    if (b != 0) ones_m++; else ones_m = 0;
    if (ones_m == 5) begin
      exp_q.push_back(0);
      ones_m = 0;
    end
  endtask

  task automatic m_byte(logic [7:0] v, bit data);
    for (int i = 0; i < 8; i++) begin
      if (data) begin
        if (crc_m[0] ^ v[i]) crc_m = (crc_m >> 1) ^ 16'h8408;
        else                 crc_m = crc_m >> 1;
      end
      m_bit(int'(v[i]));
    end
  endtask

  task automatic m_msg(bit abort);
    logic [15:0] f;
    exp_q.delete();
    m_flag();
    crc_m = 16'hFFFF;
    for (int k = 0; k < mn; k++) m_byte(mb[k], 1'b1);
    if (abort) begin
      for (int i = 0; i < 8; i++) exp_q.push_back(1);
    end else begin
      f = ~crc_m;
      m_byte(f[7:0], 1'b0);
      m_byte(f[15:8], 1'b0);
    end
    m_flag();
    m_flag();
  endtask

  task automatic tick(bit w, bit l, logic [7:0] d);
    @(negedge clk);
    bit_tick = 1; wr_en = w; wr_last = l; wr_data = d;
    @(negedge clk);
    bit_tick = 0; wr_en = 0; wr_last = 0;
    got_q.push_back(tx_valid ? int'(tx_bit) : 2);
  endtask

  task automatic wr(bit l, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_last = l; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_last = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0; bit_tick = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    got_q.delete();
  endtask

  task automatic run_cmp(string what);
    int first;
    first = -1;
    while (got_q.size() < exp_q.size()) tick(1'b0, 1'b0, 8'h00);
    for (int i = 0; i < exp_q.size(); i++)
      if (first < 0 && got_q[i] != exp_q[i]) first = i;
    chk(first < 0, $sformatf("%s (bit %0d)", what, first),
        first < 0 ? 0 : got_q[first], first < 0 ? 0 : exp_q[first]);
  endtask

  initial begin
    do_reset();
    chk(rd_data == 8'h00, "R8 reset message register", rd_data, 0);
    chk(fifo_full == 0, "R3 reset full", fifo_full, 0);
    chk(underrun == 0, "R7 reset underrun", underrun, 0);
    chk(tx_valid == 0, "R1 reset strobe", tx_valid, 0);

    exp_q.delete(); m_flag(); m_flag();
    run_cmp("R1 idle flags");
    @(negedge clk);
    chk(tx_valid == 0, "R1 no tick no strobe", tx_valid, 0);

    for (int v = 0; v < 5; v++) begin
      do_reset();
      mn = int'(VEC[v][71:64]);
      for (int k = 0; k < mn; k++) mb[k] = VEC[v][8*k +: 8];
      for (int k = 0; k < mn; k++) wr(k == mn - 1, mb[k]);
      m_msg(1'b0);
      run_cmp($sformatf("R2 R4 R5 R6 vector %0d", v));
      chk(underrun == 0, "R6 no underrun after tagged frame", underrun, 0);
    end

    do_reset();
    mn = 16;
    for (int k = 0; k < 16; k++) begin
      mb[k] = 8'(k * 17);
      wr(k == 15, mb[k]);
    end
    chk(fifo_full == 1, "R3 full at 16", fifo_full, 1);
    wr(1'b0, 8'hEE);
    chk(fifo_full == 1, "R3 full after dropped write", fifo_full, 1);
    m_msg(1'b0);
    run_cmp("R3 sixteen octets, extra write absent");
    chk(fifo_full == 0, "R3 drained", fifo_full, 0);

    do_reset();
    wr(1'b0, 8'hA5);
    chk(rd_data == 8'hA5, "R8 write loads register", rd_data, 8'hA5);
    wr(1'b1, 8'h5A);
    chk(rd_data == 8'h5A, "R8 last write loads register", rd_data, 8'h5A);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk(rd_data == 8'hA5, "R8 read latches head", rd_data, 8'hA5);

    do_reset();
    mn = 2; mb[0] = 8'h11; mb[1] = 8'h22;
    wr(1'b0, 8'h11); wr(1'b0, 8'h22);
    m_msg(1'b1);
    run_cmp("R7 abort stream");
    chk(underrun == 1, "R7 underrun set", underrun, 1);
    wr(1'b1, 8'h33);
    chk(underrun == 0, "R7 underrun cleared by write", underrun, 0);

    do_reset();
    mn = 2; mb[0] = 8'h96; mb[1] = 8'h3C;
    wr(1'b0, 8'h96);
    m_msg(1'b0);
    for (int i = 0; i < 7; i++) tick(1'b0, 1'b0, 8'h00);
    tick(1'b1, 1'b1, 8'h3C);
    run_cmp("R9 write during pop");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule